// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Ready Handshake

This block receives bytes over a clocked synchronous serial link whose shift clock is supplied from outside. Software arms it by writing the transmit buffer register; in half-duplex use the value written carries no meaning, so only the write strobe is brought in. Once armed, the receiver samples one data bit on each rising edge of the shift clock. Each new bit enters at the top of a shift register, and the register moves one place toward bit 0 on every capture. After eight bits the byte is copied into a one-entry receive buffer, a full flag is set and a one-cycle interrupt request is raised.

The receive buffer is presented as a valid/ready stream. `rb_valid` is the full flag. A cycle with both `rb_valid` and `rb_ready` high is a read, and it empties the slot. There is no back-pressure toward the serial line, because the remote end keeps clocking. If a byte completes while the slot is still full, the new byte is dropped, the old byte is kept and a sticky overrun flag is raised. An active-low ready line tells the remote end that the receiver is armed. It drops on an accepted arm write and rises again at the first falling edge of the shift clock.

The shift clock and the serial data are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the shift clock.

Top module: `ssr_rx`

## Requirements
- R1: An arm write (`arm_wr`) is accepted only while `rx_en` is high, the synchronized shift clock is high and the receiver is not already armed. Any other arm write has no effect.
- R2: `ready_n` goes low in the cycle after an accepted arm write. It returns high after the first falling edge of the shift clock that follows.
- R3: While armed, each rising edge of the shift clock captures `sdata` into the MSB of the shift register, and the register shifts one place toward the LSB. The first bit received ends up in bit 0 of the byte.
- R4: When the eighth bit is captured and the slot is free, the byte is written to `rb_data` and `rb_valid` is set. `irq` pulses high for exactly one system clock in the same cycle.
- R5: A read (`rb_valid` and `rb_ready` both high) clears `rb_valid`. `rb_data` keeps its value.
- R6: If a byte completes while `rb_valid` is high and no read occurs in that cycle, status bit 2 (overrun) is set. `rb_data` keeps the earlier byte, `rb_valid` stays high and no `irq` is raised.
- R7: The overrun flag stays set until reset, or until `ovr_clr` is pulsed high for one cycle.
- R8: After a byte completes, further shift clock edges are ignored until the next accepted arm write.
- R9: After reset, `ready_n` is 1, and `rb_valid`, `irq` and all `status` bits are 0.
- R10: `status` has bit 1 equal to the buffer-full flag and bit 2 equal to the overrun flag. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive-enabled state |
| arm_wr | input | 1 | Transmit buffer write strobe; arms reception |
| ovr_clr | input | 1 | Write of 1 to the overrun status bit; clears it |
| sclk | input | 1 | External shift clock (asynchronous) |
| sdata | input | 1 | Serial data in (asynchronous) |
| rb_data | output | 8 | Receive buffer contents |
| rb_valid | output | 1 | Receive buffer holds an unread byte |
| rb_ready | input | 1 | Consumer reads the receive buffer |
| status | output | 8 | Status: bit 1 full, bit 2 overrun |
| irq | output | 1 | Receive interrupt request, one-cycle pulse |
| ready_n | output | 1 | Active-low receive-ready line to the remote end |

## Verification
The checker watches, on every cycle, the properties that hold locally in time. These are: the interrupt is a single-cycle pulse that coincides with a full buffer; an unread buffer does not change; a read empties the slot; overrun is sticky; the status bits follow the flags; and `ready_n` only falls after an accepted arm write. Bit order, the ignored arm writes (shift clock low, receiver disabled), the refusal of bits before re-arming, and the release of `ready_n` on the first falling edge all depend on whole serial sequences. Only the bench's directed scenarios, which compare received bytes against values computed from the bits sent, can show these.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int DATA_W  = 8;
  localparam int STAT_W  = 8;
  localparam int ST_FULL = 1;
  localparam int ST_OVR  = 2;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         en,
  input  logic         rise,
  input  logic         sd,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sr_q;
  logic          take;

  assign take = en & rise;
  // Next shift value: new bit at the top, older bits move toward bit 0.
  assign word = {sd, sr_q[W-1:1]};
  assign done = take && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (take) begin
      sr_q  <= word;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssr_rxbuf.sv
module ssr_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] word,
  input  logic         rd,
  input  logic         ovr_clr,
  output logic [W-1:0] data,
  output logic         full,
  output logic         ovr,
  output logic         irq
);
  logic slot_free;

  assign slot_free = ~full | rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (done && slot_free) begin
        data <= word;
        full <= 1'b1;
        irq  <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovr <= 1'b0;
    else if (done && !slot_free) ovr <= 1'b1;
    else if (ovr_clr)            ovr <= 1'b0;
  end
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx
  import ssr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          arm_wr,
  input  logic          ovr_clr,
  input  logic          sclk,
  input  logic          sdata,
  output logic [DW-1:0] rb_data,
  output logic          rb_valid,
  input  logic          rb_ready,
  output logic [SW-1:0] status,
  output logic          irq,
  output logic          ready_n
);
  logic [1:0] sync_out;
  logic       sclk_s, sd_s, sclk_prev;
  logic       rise, fall;
  logic       armed_q, accept, done;
  logic       full, ovr, rd;
  logic [DW-1:0] word;

  ssr_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sclk, sdata}), .dout(sync_out)
  );
  assign sclk_s = sync_out[1];
  assign sd_s   = sync_out[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b1;
    else        sclk_prev <= sclk_s;
  end
  assign rise = sclk_s & ~sclk_prev;
  assign fall = ~sclk_s & sclk_prev;

  assign accept = arm_wr & rx_en & sclk_s & ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ready_n <= 1'b1;
    end else begin
      if (accept)    armed_q <= 1'b1;
      else if (done) armed_q <= 1'b0;
      if (accept)    ready_n <= 1'b0;
      else if (fall) ready_n <= 1'b1;
    end
  end

  ssr_shift #(.W(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .en(armed_q),
    .rise(rise), .sd(sd_s), .done(done), .word(word)
  );

  assign rd = rb_valid & rb_ready;

  ssr_rxbuf #(.W(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .rd(rd),
    .ovr_clr(ovr_clr), .data(rb_data), .full(full), .ovr(ovr), .irq(irq)
  );

  assign rb_valid = full;

  always_comb begin
    status          = '0;
    status[ST_FULL] = full;
    status[ST_OVR]  = ovr;
  end
endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk #(
  parameter int DW = 8,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          arm_wr,
  input logic          ovr_clr,
  input logic [DW-1:0] rb_data,
  input logic          rb_valid,
  input logic          rb_ready,
  input logic [SW-1:0] status,
  input logic          irq,
  input logic          ready_n
);
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rb_valid);
  assert_hold_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> $stable(rb_data) && rb_valid);
  assert_read_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_ready) |=> (!rb_valid || irq));
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !ovr_clr) |=> status[2]);
  assert_status_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] == rb_valid) && (status[0] == 1'b0) && (status[SW-1:3] == '0));
  assert_ready_after_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(arm_wr));
  assert_arm_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(rx_en));
endmodule

bind ssr_rx ssr_rx_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .arm_wr(arm_wr), .ovr_clr(ovr_clr),
  .rb_data(rb_data), .rb_valid(rb_valid), .rb_ready(rb_ready),
  .status(status), .irq(irq), .ready_n(ready_n)
);

// File: tb/ssr_rx_bench.sv
module ssr_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic       arm_wr = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       sclk = 1'b1;
  logic       sdata = 1'b0;
  logic       rb_ready = 1'b0;
  logic [7:0] rb_data;
  logic       rb_valid;
  logic [7:0] status;
  logic       irq;
  logic       ready_n;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ssr_rx u_ssr_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .arm_wr(arm_wr), .ovr_clr(ovr_clr),
    .sclk(sclk), .sdata(sdata), .rb_data(rb_data), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .status(status), .irq(irq), .ready_n(ready_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    arm_wr = 1'b1; tick(1); arm_wr = 1'b0; tick(1);
  endtask

  task automatic do_read();
    rb_ready = 1'b1; tick(1); rb_ready = 1'b0; tick(1);
  endtask

  // First bit sent is value bit 0, so the received byte equals v.
  task automatic send_byte(input logic [7:0] v, input bit chk_rdy);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdata = v[i]; tick(8);
      if (i == 0 && chk_rdy) check("R2 ready_n released on first fall", ready_n, 1);
      sclk = 1'b1; tick(8);
    end
    tick(4);
  endtask

  task automatic t_reset();
    check("R9 ready_n", ready_n, 1);
    check("R9 rb_valid", rb_valid, 0);
    check("R9 irq", irq, 0);
    check("R9 status", status, 0);
  endtask

  task automatic t_basic();
    int c0 = irq_cnt;
    arm();
    check("R2 ready_n low after arm", ready_n, 0);
    send_byte(8'hA5, 1'b1);
    check("R3 bit order", rb_data, 8'hA5);
    check("R4 rb_valid", rb_valid, 1);
    check("R10 status full bit", status, 8'h02);
    check("R4 single irq", irq_cnt - c0, 1);
  endtask

  task automatic t_read();
    do_read();
    check("R5 valid cleared", rb_valid, 0);
    check("R5 data kept", rb_data, 8'hA5);
    check("R10 status empty", status, 8'h00);
  endtask

  task automatic t_no_rearm();
    int c0 = irq_cnt;
    send_byte(8'h5A, 1'b0);
    check("R8 bits ignored without arm", rb_valid, 0);
    check("R8 no irq", irq_cnt - c0, 0);
  endtask

  task automatic t_overrun();
    int c0;
    arm(); send_byte(8'h3C, 1'b1);
    check("R3 second byte", rb_data, 8'h3C);
    c0 = irq_cnt;
    arm(); send_byte(8'hF0, 1'b1);
    check("R6 overrun flag", status, 8'h06);
    check("R6 old byte kept", rb_data, 8'h3C);
    check("R6 no irq on overrun", irq_cnt - c0, 0);
    tick(20);
    check("R7 overrun sticky", status[2], 1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0; tick(1);
    check("R7 overrun cleared", status[2], 0);
    check("R6 still full", rb_valid, 1);
    do_read();
  endtask

  task automatic t_arm_sclk_low();
    sclk = 1'b0; tick(6);
    arm();
    check("R1 arm ignored with sclk low", ready_n, 1);
    sclk = 1'b1; tick(8);
    send_byte(8'h81, 1'b0);
    check("R1 no byte after ignored arm", rb_valid, 0);
  endtask

  task automatic t_arm_disabled();
    rx_en = 1'b0;
    arm();
    check("R1 arm ignored while disabled", ready_n, 1);
    send_byte(8'h42, 1'b0);
    check("R1 no byte while disabled", rb_valid, 0);
    rx_en = 1'b1;
    arm(); send_byte(8'h69, 1'b1);
    check("R3 byte after re-enable", rb_data, 8'h69);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(4);
    t_reset();
    t_basic();
    t_read();
    t_no_rearm();
    t_overrun();
    t_arm_sclk_low();
    t_arm_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule